// File: doc/BRIEF.md
# Clock-Synchronous Serial Port with Armed Trigger

This block moves one byte at a time over a three- or four-wire clocked serial link. Software configures it through a small register interface: a port-ownership bit hands four pads over from general-purpose I/O to the serial unit, a second bit connects the serial output to its pad, and a mode bit chooses whether the unit generates the shift clock (master) or follows a clock supplied from outside (slave).

A transfer needs two separate steps. First, any read or write of the data register arms the shifter. Second, a trigger write starts the transfer. If either step is missing, the trigger is ignored. While the byte is moving, the trigger bit reads back as a busy flag. At the end of the eighth bit the received byte replaces the data register contents, and the unit returns to the unarmed state.

In master mode, the shift clock follows a divided clock input from elsewhere in the chip and is driven out. In slave mode, the external clock passes through a synchronizer before its edges are counted. The fourth pad then either signals readiness or acts as a select input, as chosen by a build parameter.

Top module: `ssp_top`

## Requirements
- R1: After reset the control bits, mode bit, busy flag and data register all read 0, and every pad follows the general-purpose output and output-enable inputs.
- R2: While the enable bit (control bit 0) is 0, `pad_out` and `pad_oe` equal `gpio_out` and `gpio_oe` on all four pads, whatever the mode or output-enable bits hold.
- R3: While enabled, pad 0 is an input (`pad_oe[0]`=0). Pad 2 carries the shift clock: it is driven in master mode (mode bit 0 = 1) and is an input in slave mode. In master mode, pad 3 follows the general-purpose inputs.
- R4: Pad 1 carries the serial output with `pad_oe[1]`=1 only when both the enable bit and the data-out enable (control bit 2) are 1. Otherwise pad 1 follows the general-purpose inputs.
- R5: A write of 1 to the trigger bit (control bit 1) starts a transfer only if the unit is enabled, armed and idle. A write of 0, or a write made under any other condition, leaves the busy flag at 0.
- R6: The trigger bit reads 1 from the cycle after an accepted trigger until the eighth sampling edge has been processed, and reads 0 afterwards.
- R7: In master mode the shift clock idles high and gives exactly eight low pulses per transfer, one for each falling and following rising edge of `int_clk`. Each falling edge drives the next transmit bit onto pad 1, most significant bit first, and each rising edge samples pad 0.
- R8: In slave mode the clock on `pin_clk` is synchronized with two flops. Its edges shift data the same way as in R7, and edges that arrive before an accepted trigger have no effect.
- R9: After eight bits the received byte (first bit in the most significant position) reads back from the data register (address 2). The unit becomes unarmed, so a trigger written before the next data access is ignored.
- R10: With the default build, in slave mode while enabled, pad 3 is driven (`pad_oe[3]`=1) and reads 1 while armed or busy, and 0 once a transfer has completed and before the next data access.
- R11: Data register writes made while busy are ignored. The transmitted byte and the received result are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 2 arms the shifter) |
| reg_addr | input | 2 | 0 control {dout_en, trigger/busy, enable}, 1 mode {master}, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| int_clk | input | 1 | Internal divided clock used as the master shift clock |
| pin_din | input | 1 | Serial data input from pad 0 |
| pin_clk | input | 1 | External shift clock from pad 2 |
| pin_sel | input | 1 | Active-low select from pad 3 (select build only) |
| gpio_out | input | 4 | General-purpose output values for pads 0..3 |
| gpio_oe | input | 4 | General-purpose output enables for pads 0..3 |
| pad_out | output | 4 | Output value for pads 0..3 |
| pad_oe | output | 4 | Output enable for pads 0..3 |

## Verification
Each transfer is run with a different pair of transmit and receive bytes (A5/3C, 96/4B, 01/80, FF/00). Alternating and single-bit patterns show up a shifted bit position or a reversed order, and the all-ones/all-zeros pair shows up a pad stuck at a value or a missed last bit. Master and slave transfers alternate, so clock generation is tried separately from synchronized clock following. One slave transfer is preceded by stray clock pulses, which tells apart a counter that is gated by the trigger from one that runs freely. One transfer of each mode receives a data write and a second trigger in mid-flight, which shows whether the shifter is guarded against being reloaded or restarted.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_MODE = 2'd1;
    localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

    localparam int B_EN   = 0;
    localparam int B_TRIG = 1;
    localparam int B_DOE  = 2;
    localparam int B_MST  = 0;

    localparam int NPADS    = 4;
    localparam int PAD_DIN  = 0;
    localparam int PAD_DOUT = 1;
    localparam int PAD_CLK  = 2;
    localparam int PAD_HS   = 3;
endpackage

// File: rtl/ssp_in_sync.sv
module ssp_in_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] sync
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = raw;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], raw};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync = chain_q[STAGES-1];
endmodule

// File: rtl/ssp_pin_mux.sv
module ssp_pin_mux
    import ssp_pkg::*;
#(
    parameter int SEL_MODE = 0
) (
    input  logic             en,
    input  logic             dout_en,
    input  logic             master,
    input  logic             sout,
    input  logic             sclk,
    input  logic             ready,
    input  logic [NPADS-1:0] gpio_out,
    input  logic [NPADS-1:0] gpio_oe,
    output logic [NPADS-1:0] pad_out,
    output logic [NPADS-1:0] pad_oe
);
    localparam bit HS_IS_SEL = (SEL_MODE != 0);

    always_comb begin
        pad_out = gpio_out;
        pad_oe  = gpio_oe;
        if (en) begin
            pad_out[PAD_DIN] = 1'b0;
            pad_oe[PAD_DIN]  = 1'b0;
            if (dout_en) begin
                pad_out[PAD_DOUT] = sout;
                pad_oe[PAD_DOUT]  = 1'b1;
            end
            if (master) begin
                pad_out[PAD_CLK] = sclk;
                pad_oe[PAD_CLK]  = 1'b1;
            end else begin
                pad_out[PAD_CLK] = 1'b0;
                pad_oe[PAD_CLK]  = 1'b0;
                pad_out[PAD_HS]  = HS_IS_SEL ? 1'b0 : ready;
                pad_oe[PAD_HS]   = !HS_IS_SEL;
            end
        end
    end
endmodule

// File: rtl/ssp_top.sv
module ssp_top
    import ssp_pkg::*;
#(
    parameter int DW = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SEL_MODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              int_clk,
    input  logic              pin_din,
    input  logic              pin_clk,
    input  logic              pin_sel,
    input  logic [NPADS-1:0]  gpio_out,
    input  logic [NPADS-1:0]  gpio_oe,
    output logic [NPADS-1:0]  pad_out,
    output logic [NPADS-1:0]  pad_oe
);
    localparam int CNT_W = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DW - 1);

    typedef struct packed {
        logic             en;
        logic             dout_en;
        logic             master;
        logic             armed;
        logic             busy;
        logic             phase_low;
        logic             sout;
        logic             int_prev;
        logic             ext_prev;
        logic [CNT_W-1:0] cnt;
        logic [DW-1:0]    data;
        logic [DW-1:0]    shreg;
    } st_t;

    st_t st_d, st_q;

    // synchronized pad inputs: {select, clock, data}
    logic [2:0] pins_s;
    logic din_s, clk_s, sel_s;

    ssp_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({pin_sel, pin_clk, pin_din}),
        .sync  (pins_s)
    );
    assign din_s = pins_s[0];
    assign clk_s = pins_s[1];
    assign sel_s = pins_s[2];

    logic slave_gate;
    assign slave_gate = (SEL_MODE != 0) ? !sel_s : 1'b1;

    logic wr_ctrl, wr_mode, wr_data, rd_data, trig_ok;
    logic fall_ev, rise_ev;
    logic [DW-1:0] shifted;

    always_comb begin
        st_d = st_q;
        wr_ctrl = reg_wr && (reg_addr == A_CTRL);
        wr_mode = reg_wr && (reg_addr == A_MODE);
        wr_data = reg_wr && (reg_addr == A_DATA);
        rd_data = reg_rd && (reg_addr == A_DATA);
        trig_ok = wr_ctrl && reg_wdata[B_TRIG] && st_q.en && st_q.armed && !st_q.busy;

        st_d.int_prev = int_clk;
        st_d.ext_prev = clk_s;

        if (st_q.master) begin
            fall_ev = st_q.int_prev && !int_clk;
            rise_ev = !st_q.int_prev && int_clk;
        end else begin
            fall_ev = slave_gate && st_q.ext_prev && !clk_s;
            rise_ev = slave_gate && !st_q.ext_prev && clk_s;
        end
        shifted = {st_q.shreg[DW-2:0], din_s};

        if (wr_ctrl) begin
            st_d.en      = reg_wdata[B_EN];
            st_d.dout_en = reg_wdata[B_DOE];
        end
        if (wr_mode) st_d.master = reg_wdata[B_MST];

        // a data access arms the shifter, but only between transfers
        if (!st_q.busy && (wr_data || rd_data)) begin
            st_d.armed = 1'b1;
            if (wr_data) st_d.data = reg_wdata;
        end

        if (trig_ok) begin
            st_d.busy      = 1'b1;
            st_d.shreg     = st_q.data;
            st_d.cnt       = '0;
            st_d.phase_low = 1'b0;
        end

        if (st_q.busy && fall_ev) begin
            st_d.phase_low = 1'b1;
            st_d.sout      = st_q.shreg[DW-1];
        end
        if (st_q.busy && rise_ev && st_q.phase_low) begin
            st_d.phase_low = 1'b0;
            st_d.shreg     = shifted;
            st_d.cnt       = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy  = 1'b0;
                st_d.armed = 1'b0;
                st_d.data  = shifted;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL: begin
                reg_rdata[B_EN]   = st_q.en;
                reg_rdata[B_TRIG] = st_q.busy;
                reg_rdata[B_DOE]  = st_q.dout_en;
            end
            A_MODE:  reg_rdata[B_MST] = st_q.master;
            A_DATA:  reg_rdata = st_q.data;
            default: reg_rdata = '0;
        endcase
    end

    ssp_pin_mux #(.SEL_MODE(SEL_MODE)) u_mux (
        .en       (st_q.en),
        .dout_en  (st_q.dout_en),
        .master   (st_q.master),
        .sout     (st_q.sout),
        .sclk     (!st_q.phase_low),
        .ready    (st_q.armed || st_q.busy),
        .gpio_out (gpio_out),
        .gpio_oe  (gpio_oe),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    // state views for the bound checker
    logic          chk_en, chk_master, chk_busy, chk_armed;
    logic [DW-1:0] chk_data;
    assign chk_en     = st_q.en;
    assign chk_master = st_q.master;
    assign chk_busy   = st_q.busy;
    assign chk_armed  = st_q.armed;
    assign chk_data   = st_q.data;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
    parameter int DW = 8,
    parameter int SEL_MODE = 0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          master,
    input logic          busy,
    input logic          armed,
    input logic [DW-1:0] data,
    input logic [3:0]    gpio_out,
    input logic [3:0]    gpio_oe,
    input logic [3:0]    pad_out,
    input logic [3:0]    pad_oe
);
    p_trig_needs_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(armed) && $past(en)));

    p_done_clears_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !armed);

    p_gpio_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (pad_out == gpio_out && pad_oe == gpio_oe));

    p_din_is_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> !pad_oe[0]);

    p_sclk_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && master && !busy) |-> (pad_out[2] && pad_oe[2]));

    p_data_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(data));

    generate
        if (SEL_MODE == 0) begin : g_ready
            p_ready_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (en && !master) |-> (pad_oe[3] && (pad_out[3] == (armed || busy))));
        end
    endgenerate
endmodule

bind ssp_top ssp_checker #(.DW(DW), .SEL_MODE(SEL_MODE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (chk_en),
    .master   (chk_master),
    .busy     (chk_busy),
    .armed    (chk_armed),
    .data     (chk_data),
    .gpio_out (gpio_out),
    .gpio_oe  (gpio_oe),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
);

// File: tb/tb_ssp_top.sv
module tb_ssp_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       int_clk = 1'b1;
    logic       sin_tb = 1'b0, ext_clk = 1'b1, sel_tb = 1'b0;
    logic [3:0] gpio_out = 4'b1010, gpio_oe = 4'b0110;
    logic [3:0] pad_out, pad_oe;

    always #5 clk = ~clk;

    ssp_top dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .int_clk(int_clk), .pin_din(sin_tb), .pin_clk(ext_clk), .pin_sel(sel_tb),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    int checks = 0, errors = 0;

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // free-running internal clock for master mode
    initial forever begin
        repeat (6) @(negedge clk);
        int_clk = ~int_clk;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    // register access
    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // peer device model and scoreboard
    logic       tb_master = 1'b0;
    logic       mon_on = 1'b0;
    logic [7:0] peer_tx = '0;
    logic [7:0] cap = '0;
    int         pbit = 0;
    int         mfalls = 0;
    logic [7:0] exp_q[$];
    logic       sclk_line;
    assign sclk_line = tb_master ? pad_out[2] : ext_clk;

    always @(negedge sclk_line) if (mon_on) begin
        sin_tb = peer_tx[7 - pbit];
        if (tb_master) mfalls++;
    end

    always @(posedge sclk_line) if (mon_on) begin
        cap = {cap[6:0], pad_out[1]};
        pbit++;
        if (pbit == 8) begin
            if (exp_q.size() == 0) begin
                chk_eq("R7 frame with nothing expected", {24'd0, cap}, 32'hFFFF);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk_eq(tb_master ? "R7 master tx frame on pad1" : "R8 slave tx frame on pad1",
                       {24'd0, cap}, {24'd0, e});
            end
            pbit = 0;
        end
    end

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_clk = 1'b0;
            repeat (8) @(negedge clk);
            ext_clk = 1'b1;
            repeat (8) @(negedge clk);
        end
    endtask

    task automatic run_xfer(input bit m, input logic [7:0] tx, input logic [7:0] rx,
                            input bit poke, input bit stray);
        logic [7:0] v;
        tb_master = m;
        reg_write(2'd1, {7'd0, m});
        reg_write(2'd2, tx);
        if (!m) chk_eq("R10 ready while armed", {30'd0, pad_oe[3], pad_out[3]}, 32'h3);
        if (stray) begin
            ext_pulses(3);
            reg_read(2'd0, v);
            chk_eq("R8 stray clocks leave unit idle", {31'd0, v[1]}, 32'd0);
        end
        exp_q.push_back(tx);
        peer_tx = rx; pbit = 0; mfalls = 0; mon_on = 1'b1;
        reg_write(2'd0, 8'b0000_0111);
        reg_read(2'd0, v);
        chk_eq("R6 busy after trigger", {31'd0, v[1]}, 32'd1);
        if (poke) begin
            reg_write(2'd2, 8'hFF);
            reg_write(2'd0, 8'b0000_0111);
            reg_read(2'd0, v);
            chk_eq("R11 busy kept after repeat trigger", {31'd0, v[1]}, 32'd1);
        end
        if (!m) ext_pulses(8);
        for (int i = 0; i < 300; i++) begin
            reg_read(2'd0, v);
            if (!v[1]) break;
        end
        chk_eq("R6 busy clears after eight bits", {31'd0, v[1]}, 32'd0);
        if (!m) chk_eq("R10 ready drops at completion", {30'd0, pad_oe[3], pad_out[3]}, 32'h2);
        repeat (30) @(negedge clk);
        mon_on = 1'b0;
        chk_eq("R7 frame delivered", exp_q.size(), 32'd0);
        if (m) chk_eq("R7 exactly eight clock pulses", mfalls, 32'd8);
        reg_write(2'd0, 8'b0000_0111);
        reg_read(2'd0, v);
        chk_eq("R9 trigger ignored when unarmed", {31'd0, v[1]}, 32'd0);
        reg_read(2'd2, v);
        chk_eq("R9 received byte", {24'd0, v}, {24'd0, rx});
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_eq("R1 pad_out after reset", {28'd0, pad_out}, 32'hA);
        chk_eq("R1 pad_oe after reset", {28'd0, pad_oe}, 32'h6);
        reg_read(2'd0, v); chk_eq("R1 control reset", {24'd0, v}, 32'd0);
        reg_read(2'd1, v); chk_eq("R1 mode reset", {24'd0, v}, 32'd0);
        reg_read(2'd2, v); chk_eq("R1 data reset", {24'd0, v}, 32'd0);

        // R2 disabled: pads follow gpio even with other bits set
        reg_write(2'd1, 8'h01);
        reg_write(2'd0, 8'b0000_0100);
        gpio_out = 4'b0101; gpio_oe = 4'b1111;
        @(negedge clk);
        chk_eq("R2 pad_out passthrough", {28'd0, pad_out}, 32'h5);
        chk_eq("R2 pad_oe passthrough", {28'd0, pad_oe}, 32'hF);

        // R5 trigger while disabled (armed by the data read above)
        reg_write(2'd0, 8'b0000_0010);
        reg_read(2'd0, v);
        chk_eq("R5 trigger ignored when disabled", {31'd0, v[1]}, 32'd0);

        // R3 / R4 pin roles, slave then master
        gpio_out = 4'b1011; gpio_oe = 4'b1010;
        reg_write(2'd1, 8'h00);
        reg_write(2'd0, 8'b0000_0101);
        reg_read(2'd0, v);
        chk_eq("R5 write of zero to trigger has no effect", {24'd0, v}, 32'h5);
        chk_eq("R3 slave: din and clk are inputs", {30'd0, pad_oe[2], pad_oe[0]}, 32'd0);
        chk_eq("R4 dout driven when enabled", {31'd0, pad_oe[1]}, 32'd1);
        chk_eq("R10 ready driven in slave mode", {30'd0, pad_oe[3], pad_out[3]}, 32'h3);
        reg_write(2'd1, 8'h01);
        chk_eq("R3 master: clk driven idle high", {30'd0, pad_oe[2], pad_out[2]}, 32'h3);
        chk_eq("R3 master: pad3 follows gpio", {30'd0, pad_oe[3], pad_out[3]}, 32'h3);
        reg_write(2'd0, 8'b0000_0001);
        chk_eq("R4 dout disabled follows gpio", {30'd0, pad_oe[1], pad_out[1]}, 32'h3);

        // transfers with varied patterns
        run_xfer(1'b1, 8'hA5, 8'h3C, 1'b1, 1'b0);
        run_xfer(1'b0, 8'h96, 8'h4B, 1'b1, 1'b1);
        run_xfer(1'b1, 8'h01, 8'h80, 1'b0, 1'b0);
        run_xfer(1'b0, 8'hFF, 8'h00, 1'b0, 1'b0);

        finish_run();
    end
endmodule